// File: doc/BRIEF.md
# Byte-Lane Inter-Core Exchange Fabric

This block is a shared 32-bit word exchange among eight cores. Each core owns three registers: a data word, a direction (enable) word and a filter word. What a core contributes to the fabric is its data word with every bit cleared wherever its direction word holds zero. Each core also reads back a 32-bit word assembled from the other cores' contributions. The assembly is done one byte at a time.

The filter word holds four 8-bit core-select masks, one for each byte lane of the reader's input. Every core flagged in a lane's mask has its byte in that lane ORed into the reader's byte. Several cores can feed one lane at once, and a core may select itself. A lane with an empty mask reads zero. A typical use has one core read another's full word. In another, a gathering core collects single bytes or half-words from several producers into one result word.

Register writes reach the read port with a fixed latency. Both the filter path and the driven-data path pass through one matched pipeline stage, and the read port itself is a register. The reads in the two cycles after a write still show the old result. The third cycle shows the new one.

Top module: `xchg_fabric`

## Requirements
- R1: The word a core contributes is its data register ANDed bit by bit with its direction register; bits with direction 0 contribute 0.
- R2: Filter bits [8k+7:8k] form the select mask for input byte k (k = 0..3) of the reading core; a mask affects only its own byte.
- R3: Bit n of a lane mask set means core n's contributed byte in that lane is ORed into the reader's byte; a reader's byte never holds a 1 that no selected core contributes.
- R4: Filter 0x01010101 returns core 0's full contributed word; filter 0x03030303 returns the bitwise OR of cores 0 and 1.
- R5: A lane whose 8-bit mask is zero reads 0x00.
- R6: After a filter write sampled on clock edge E, the read port shows old-filter data after E and E+1, and new-filter data after E+2.
- R7: A write to a data or direction register sampled on edge E is visible on every selecting reader's port after E+2 and not before.
- R8: A core that selects itself in a mask sees its own contribution in that lane.
- R9: On reset all data, direction and filter registers and all read ports are zero; an active-low asynchronous reset clears the read ports at once.
- R10: A write strobe for core n changes only core n's registers; other cores' filters and contributions are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_we_i | input | 8 | Per-core data register write strobe |
| data_wdata_i | input | 256 | Data write values, core n at [32n+31:32n] |
| dir_we_i | input | 8 | Per-core direction register write strobe |
| dir_wdata_i | input | 256 | Direction write values, core n at [32n+31:32n] |
| filt_we_i | input | 8 | Per-core filter register write strobe |
| filt_wdata_i | input | 256 | Filter write values, core n at [32n+31:32n] |
| rdata_o | output | 256 | Filtered input word per core, core n at [32n+31:32n] |

## Verification
The checker watches four behaviours on every cycle. Each contribution must stay within its direction mask one stage later. A lane with an empty mask must read zero. No read byte may show a bit that no core contributed. The read ports must stay steady whenever no write happened three edges earlier. Some behaviours show only in the bench's scenarios: the exact OR of the selected cores, which mask bits map to which byte, self-selection, the old-old-new read sequence after filter and data writes, and per-core isolation. These need chosen data patterns and expected words.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  localparam int unsigned NUM_CORES = 8;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned LANE_W    = 8;
  localparam int unsigned NUM_LANES = WORD_W / LANE_W;
endpackage

// File: rtl/xchg_core_regs.sv
module xchg_core_regs #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned FILT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_we_i,
  input  logic [WORD_W-1:0] data_wdata_i,
  input  logic              dir_we_i,
  input  logic [WORD_W-1:0] dir_wdata_i,
  input  logic              filt_we_i,
  input  logic [FILT_W-1:0] filt_wdata_i,
  output logic [WORD_W-1:0] data_o,
  output logic [WORD_W-1:0] dir_o,
  output logic [WORD_W-1:0] drive_o,
  output logic [FILT_W-1:0] filt_o
);
  logic [WORD_W-1:0] data_q, dir_q, drive_q;
  logic [FILT_W-1:0] filt_q, filt_p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
      filt_q <= '0;
    end else begin
      if (data_we_i) data_q <= data_wdata_i;
      if (dir_we_i)  dir_q  <= dir_wdata_i;
      if (filt_we_i) filt_q <= filt_wdata_i;
    end
  end

  // matched stage: masked data and filter move together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drive_q  <= '0;
      filt_p_q <= '0;
    end else begin
      drive_q  <= data_q & dir_q;
      filt_p_q <= filt_q;
    end
  end

  assign data_o  = data_q;
  assign dir_o   = dir_q;
  assign drive_o = drive_q;
  assign filt_o  = filt_p_q;
endmodule

// File: rtl/xchg_lane_or.sv
module xchg_lane_or #(
  parameter int unsigned NUM_CORES = 8,
  parameter int unsigned LANE_W    = 8
) (
  input  logic [NUM_CORES*LANE_W-1:0] src_i,
  input  logic [NUM_CORES-1:0]        sel_i,
  output logic [LANE_W-1:0]           lane_o
);
  always_comb begin
    lane_o = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      lane_o = lane_o | (src_i[c*LANE_W +: LANE_W] & {LANE_W{sel_i[c]}});
    end
  end
endmodule

// File: rtl/xchg_fabric.sv
module xchg_fabric
  import xchg_pkg::*;
#(
  parameter int unsigned N_CORES = NUM_CORES,
  parameter int unsigned W_WORD  = WORD_W,
  parameter int unsigned W_LANE  = LANE_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_CORES-1:0]        data_we_i,
  input  logic [N_CORES*W_WORD-1:0] data_wdata_i,
  input  logic [N_CORES-1:0]        dir_we_i,
  input  logic [N_CORES*W_WORD-1:0] dir_wdata_i,
  input  logic [N_CORES-1:0]        filt_we_i,
  input  logic [N_CORES*W_WORD-1:0] filt_wdata_i,
  output logic [N_CORES*W_WORD-1:0] rdata_o
);
  localparam int unsigned N_LANES = W_WORD / W_LANE;
  localparam int unsigned FILT_W  = N_LANES * N_CORES;
  localparam int unsigned FLAT_W  = N_CORES * W_WORD;

  logic [FLAT_W-1:0]         data_w, dir_w, drive_w;
  logic [N_CORES*FILT_W-1:0] filt_w;
  logic [N_LANES-1:0][N_CORES*W_LANE-1:0] lane_src;
  logic [FLAT_W-1:0]         rdata_nxt, rdata_q;

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    xchg_core_regs #(.WORD_W(W_WORD), .FILT_W(FILT_W)) u_regs (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .data_we_i    (data_we_i[c]),
      .data_wdata_i (data_wdata_i[c*W_WORD +: W_WORD]),
      .dir_we_i     (dir_we_i[c]),
      .dir_wdata_i  (dir_wdata_i[c*W_WORD +: W_WORD]),
      .filt_we_i    (filt_we_i[c]),
      .filt_wdata_i (filt_wdata_i[c*W_WORD +: FILT_W]),
      .data_o       (data_w[c*W_WORD +: W_WORD]),
      .dir_o        (dir_w[c*W_WORD +: W_WORD]),
      .drive_o      (drive_w[c*W_WORD +: W_WORD]),
      .filt_o       (filt_w[c*FILT_W +: FILT_W])
    );
    for (genvar l = 0; l < N_LANES; l++) begin : g_src
      assign lane_src[l][c*W_LANE +: W_LANE] = drive_w[c*W_WORD + l*W_LANE +: W_LANE];
    end
  end

  // reader r, lane l: OR of cores picked by mask bits [l*N_CORES +: N_CORES]
  for (genvar r = 0; r < N_CORES; r++) begin : g_rd
    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
      xchg_lane_or #(.NUM_CORES(N_CORES), .LANE_W(W_LANE)) u_or (
        .src_i  (lane_src[l]),
        .sel_i  (filt_w[r*FILT_W + l*N_CORES +: N_CORES]),
        .lane_o (rdata_nxt[r*W_WORD + l*W_LANE +: W_LANE])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_nxt;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/xchg_fabric_chk.sv
module xchg_fabric_chk #(
  parameter int unsigned N_CORES = 8,
  parameter int unsigned W_WORD  = 32,
  parameter int unsigned W_LANE  = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [N_CORES-1:0]        data_we_i,
  input logic [N_CORES-1:0]        dir_we_i,
  input logic [N_CORES-1:0]        filt_we_i,
  input logic [N_CORES*W_WORD-1:0] data_w,
  input logic [N_CORES*W_WORD-1:0] dir_w,
  input logic [N_CORES*W_WORD-1:0] drive_w,
  input logic [N_CORES*(W_WORD/W_LANE)*N_CORES-1:0] filt_w,
  input logic [N_CORES*W_WORD-1:0] rdata_o
);
  localparam int unsigned N_LANES = W_WORD / W_LANE;
  localparam int unsigned FILT_W  = N_LANES * N_CORES;

  logic any_we;
  logic [W_WORD-1:0] or_all;
  assign any_we = |{data_we_i, dir_we_i, filt_we_i};

  always_comb begin
    or_all = '0;
    for (int c = 0; c < N_CORES; c++) or_all = or_all | drive_w[c*W_WORD +: W_WORD];
  end

  // R9
  rst_zero_chk: assert property (@(posedge clk_i) !rst_ni |-> rdata_o == '0);

  // R6
  quiet_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(any_we, 3) |-> $stable(rdata_o));

  for (genvar c = 0; c < N_CORES; c++) begin : g_c
    // R1
    drive_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (drive_w[c*W_WORD +: W_WORD] & ~$past(dir_w[c*W_WORD +: W_WORD])) == '0);
    // R1
    drive_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (drive_w[c*W_WORD +: W_WORD] & ~$past(data_w[c*W_WORD +: W_WORD])) == '0);
    for (genvar l = 0; l < N_LANES; l++) begin : g_l
      // R5
      empty_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(filt_w[c*FILT_W + l*N_CORES +: N_CORES]) == '0
        |-> rdata_o[c*W_WORD + l*W_LANE +: W_LANE] == '0);
      // R3
      no_phantom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rdata_o[c*W_WORD + l*W_LANE +: W_LANE] & ~$past(or_all[l*W_LANE +: W_LANE])) == '0);
    end
  end
endmodule

bind xchg_fabric xchg_fabric_chk #(.N_CORES(N_CORES), .W_WORD(W_WORD), .W_LANE(W_LANE)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .data_we_i (data_we_i),
  .dir_we_i  (dir_we_i),
  .filt_we_i (filt_we_i),
  .data_w    (data_w),
  .dir_w     (dir_w),
  .drive_w   (drive_w),
  .filt_w    (filt_w),
  .rdata_o   (rdata_o)
);

// File: tb/xchg_fabric_tb_top.sv
module xchg_fabric_tb_top;
  localparam int NC = 8;
  localparam int W  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0]   data_we = '0, dir_we = '0, filt_we = '0;
  logic [NC*W-1:0] data_wd = '0, dir_wd = '0, filt_wd = '0;
  logic [NC*W-1:0] rdata;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  xchg_fabric dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .data_we_i    (data_we),
    .data_wdata_i (data_wd),
    .dir_we_i     (dir_we),
    .dir_wdata_i  (dir_wd),
    .filt_we_i    (filt_we),
    .filt_wdata_i (filt_wd),
    .rdata_o      (rdata)
  );

  // reader n = index n; data pattern: core n drives 1<<n in every byte
  localparam logic [31:0] VEC_FILT [8] = '{
    32'h01010101, 32'h03030303, 32'h00000000, 32'h08040201,
    32'h00001000, 32'h80808080, 32'hFFFFFFFF, 32'h0000FF00};
  localparam logic [31:0] VEC_EXP [8] = '{
    32'h01010101, 32'h03030303, 32'h00000000, 32'h08040201,
    32'h00001000, 32'h00800080, 32'h7FFF7FFF, 32'h00007F00};
  localparam string VEC_REQ [8] = '{"R4", "R4", "R5", "R2", "R8", "R1", "R3", "R5"};

  task automatic check(input string req, input int core, input logic [31:0] exp);
    logic [31:0] act;
    act = rdata[core*W +: W];
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s core%0d act=%08h exp=%08h", req, core, act, exp);
    end
  endtask

  // call at negedge; returns at the first negedge after the write edge
  task automatic wr(input int kind, input int core, input logic [31:0] val);
    case (kind)
      0: begin data_we[core] = 1'b1; data_wd[core*W +: W] = val; end
      1: begin dir_we[core]  = 1'b1; dir_wd[core*W +: W]  = val; end
      default: begin filt_we[core] = 1'b1; filt_wd[core*W +: W] = val; end
    endcase
    @(posedge clk);
    @(negedge clk);
    data_we = '0; dir_we = '0; filt_we = '0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < NC; c++) check("R9", c, 32'h0);

    // setup data/direction for all cores in one edge
    for (int c = 0; c < NC; c++) begin
      data_wd[c*W +: W] = {4{8'(1 << c)}};
      dir_wd[c*W +: W]  = (c == 7) ? 32'h00FF00FF : 32'hFFFFFFFF;
    end
    data_we = '1; dir_we = '1;
    @(posedge clk);
    @(negedge clk);
    data_we = '0; dir_we = '0;
    repeat (3) @(negedge clk);
    // filters still zero: nothing visible
    check("R5", 0, 32'h0);

    for (int i = 0; i < 8; i++) begin
      wr(2, i, VEC_FILT[i]);
      @(negedge clk);
      @(negedge clk);
      check(VEC_REQ[i], i, VEC_EXP[i]);
    end
    // R10: later filter writes left earlier readers intact
    check("R10", 0, 32'h01010101);
    check("R10", 3, 32'h08040201);

    // R6: filter change timing on core 0
    wr(2, 0, 32'h02020202);
    check("R6", 0, 32'h01010101);
    @(negedge clk); check("R6", 0, 32'h01010101);
    @(negedge clk); check("R6", 0, 32'h02020202);

    // R7: data write timing, core 1 feeding core 0
    wr(0, 1, 32'hA5A5A5A5);
    check("R7", 0, 32'h02020202);
    @(negedge clk); check("R7", 0, 32'h02020202);
    @(negedge clk); check("R7", 0, 32'hA5A5A5A5);

    // R1: direction change on core 1, same latency
    wr(1, 1, 32'h0000FFFF);
    check("R7", 0, 32'hA5A5A5A5);
    @(negedge clk);
    @(negedge clk); check("R1", 0, 32'h0000A5A5);

    // R10: clearing core 2's filter leaves core 0 untouched
    wr(2, 2, 32'h02020202);
    @(negedge clk);
    @(negedge clk);
    check("R10", 2, 32'h0000A5A5);
    wr(2, 2, 32'h0);
    @(negedge clk);
    @(negedge clk);
    check("R10", 0, 32'h0000A5A5);
    check("R5", 2, 32'h0);

    // R9: asynchronous reset mid-run
    #3 rst_n = 1'b0;
    #2;
    check("R9", 0, 32'h0);
    check("R9", 6, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    wr(2, 0, 32'hFFFFFFFF);
    @(negedge clk);
    @(negedge clk);
    check("R9", 0, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule